// File: doc/BRIEF.md
# Maskable Interrupt Status Aggregator

This block gathers event lines from several source groups into eight-bit status registers, one per group. Each status register has a mask register beside it. A mask bit at one stops the matching status bit from reaching the interrupt pin and the summary register. A summary register holds one bit per group. The single interrupt pin is the OR of those summary bits. A software handler reads the summary to find which group needs service, then reads that group's status register, and that read clears it.

A control register holds two bits. The visibility bit decides whether masked events are still recorded in the status registers, where software can poll them. Masked events never reach the summary or the pin, whatever the visibility bit says. The polarity bit selects whether the pin is active-high or active-low. All registers sit on a simple synchronous bus with separate read and write strobes, and read data is registered.

The address map follows from `NGROUPS` (N). Status registers are at 0..N-1. Mask registers are at N..2N-1. The control register is at 2N, with bit 0 as visibility and bit 1 as polarity (1 = active-high). The summary register is at 2N+1, where bit g stands for group g.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every mask register reads 0xFF, every status register reads 0x00, the control register reads 0x00, and the pin sits at its inactive level, which is high because the reset polarity is active-low.
- R2: A status bit is set by a 0-to-1 transition of its event input. An input held high sets the bit only once, so after the bit has been read and cleared it stays clear while the input stays high.
- R3: A read of status register g returns its contents one cycle after the read strobe and clears the register. If an event arrives in the same cycle as the read, its bit is set after the read.
- R4: Mask register g (address N+g) is read/write. A 1 in bit b blocks status bit b of group g, and a 0 lets it through.
- R5: When the visibility bit is 0, an event whose mask bit is 1 leaves its status bit clear.
- R6: When the visibility bit is 1, an event whose mask bit is 1 is recorded in the status register and can be read there, but it does not show in the summary or on the pin.
- R7: Summary bit g (address 2N+1) is 1 exactly when group g has a status bit that is set and unmasked.
- R8: The pin is active when any summary bit is 1. With polarity bit 1 the active level is high, and with polarity bit 0 it is low.
- R9: Clearing a mask bit whose status bit is already set makes the pin active right after the clock edge that performs the write.
- R10: Writes to status or summary addresses have no effect, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | NGROUPS*8 | Event lines; bits 8g..8g+7 belong to group g |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| irq_o | output | 1 | Interrupt pin, level set by the polarity bit |

## Verification
An event edge sampled at a rising clock edge shows up in the status register, the summary and the pin right after that same edge. Read data appears one edge after the read strobe is sampled, and a mask or control write takes effect at the edge that samples it. The bench drives all inputs on falling edges. At every falling edge it compares the pin and the read data with a behavioural model that is advanced on rising edges. Directed checks read registers one cycle after each strobe, so every result is sampled half a cycle after the edge that produces it.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NGROUPS = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NGROUPS*8-1:0]   ev_i,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  output logic                   irq_o
);
  localparam int W      = 8;
  localparam int NB     = NGROUPS * W;
  localparam int A_MASK = NGROUPS;
  localparam int A_CTRL = 2 * NGROUPS;
  localparam int A_SUM  = 2 * NGROUPS + 1;

  logic [NB-1:0]      st_q, mask_q, ev_q, clr_v;
  logic [NGROUPS-1:0] sum;
  logic               vis_q, pol_q;
  logic [7:0]         rd_mux;

  wire [NB-1:0] rise  = ev_i & ~ev_q;
  wire [NB-1:0] set_v = rise & ~(mask_q & {NB{~vis_q}});

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    assign clr_v[g*W +: W] = {W{rd_en && addr == ADDR_W'(g)}};
    assign sum[g] = |(st_q[g*W +: W] & ~mask_q[g*W +: W]);
  end

  assign irq_o = pol_q ? (|sum) : ~(|sum);

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NGROUPS; g++) begin
      if (addr == ADDR_W'(g))          rd_mux = st_q[g*W +: W];
      if (addr == ADDR_W'(A_MASK + g)) rd_mux = mask_q[g*W +: W];
    end
    if (addr == ADDR_W'(A_CTRL)) rd_mux = {6'b0, pol_q, vis_q};
    if (addr == ADDR_W'(A_SUM))  rd_mux = W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= '0;
      mask_q <= '1;
      ev_q   <= '0;
      vis_q  <= 1'b0;
      pol_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      st_q <= (st_q & ~clr_v) | set_v;
      ev_q <= ev_i;
      if (rd_en) rdata <= rd_mux;
      if (wr_en) begin
        for (int g = 0; g < NGROUPS; g++)
          if (addr == ADDR_W'(A_MASK + g)) mask_q[g*W +: W] <= wdata;
        if (addr == ADDR_W'(A_CTRL)) {pol_q, vis_q} <= wdata[1:0];
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (mask_q == '1 && st_q == '0 && irq_o == 1'b1));

  assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & ~mask_q)) |=> ((st_q & $past(rise & ~mask_q)) == $past(rise & ~mask_q)));

  for (genvar g = 0; g < NGROUPS; g++) begin : g_chk
    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(g) && rise[g*W +: W] == '0) |=> st_q[g*W +: W] == '0);
  end

  assert_masked_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !vis_q |=> ((st_q & ~$past(st_q) & $past(mask_q)) == '0));

  assert_pin_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o == pol_q) == (|(st_q & ~mask_q))));

  assert_unmask_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_MASK) && (|(st_q[W-1:0] & mask_q[W-1:0] & ~wdata))
     && !(rd_en && addr == '0)) |=> irq_o == pol_q);

  assert_status_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr < ADDR_W'(NGROUPS) && !rd_en && rise == '0) |=> $stable(st_q));
endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
  localparam int NG = 4;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [NG*8-1:0] ev = '0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  wire  [7:0] rdata;
  wire        irq;

  irq_aggregator #(.NGROUPS(NG), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq));

  always #2 clk = ~clk;

  int checks = 0, bad = 0;
  string phase = "R1";
  int m_st[NG], m_mask[NG], m_evq[NG], nst[NG];
  int m_vis, m_pol, m_rd;

  function automatic int m_sum();
    int s = 0;
    for (int g = 0; g < NG; g++) if ((m_st[g] & ~m_mask[g] & 255) != 0) s |= (1 << g);
    return s;
  endfunction

  function automatic int m_read(int a);
    if (a < NG) return m_st[a];
    if (a < 2*NG) return m_mask[a-NG];
    if (a == 2*NG) return m_pol*2 + m_vis;
    if (a == 2*NG+1) return m_sum();
    return 0;
  endfunction

  function automatic int m_irq();
    return (m_pol != 0) ? (m_sum() != 0) : (m_sum() == 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) begin m_st[g] = 0; m_mask[g] = 255; m_evq[g] = 0; end
      m_vis = 0; m_pol = 0; m_rd = 0;
    end else begin
      if (rd_en) m_rd = m_read(int'(addr));
      for (int g = 0; g < NG; g++) begin
        int e, r;
        e = int'(ev[g*8 +: 8]);
        r = e & ~m_evq[g] & 255;
        nst[g] = ((rd_en && int'(addr) == g) ? 0 : m_st[g]) |
                 (r & ((m_vis != 0) ? 255 : (~m_mask[g] & 255)));
        m_evq[g] = e;
      end
      if (wr_en) begin
        if (int'(addr) >= NG && int'(addr) < 2*NG) m_mask[int'(addr)-NG] = int'(wdata);
        if (int'(addr) == 2*NG) begin m_vis = int'(wdata[0]); m_pol = int'(wdata[1]); end
      end
      for (int g = 0; g < NG; g++) m_st[g] = nst[g];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({phase, " model rdata"}, int'(rdata), m_rd);
    chk({phase, " model irq"}, int'(irq), m_irq());
  end

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; addr = AW'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); rd_en = 1; addr = AW'(a);
    @(negedge clk); rd_en = 0; d = int'(rdata);
  endtask

  task automatic pulse(int g, int b);
    @(negedge clk); ev[g*8+b] = 1'b1;
    @(negedge clk); ev[g*8+b] = 1'b0;
  endtask

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    rd(NG, d);     chk("R1 mask0 reset", d, 8'hFF);
    rd(2*NG, d);   chk("R1 ctrl reset", d, 0);
    rd(1, d);      chk("R1 status1 reset", d, 0);
    chk("R1 pin inactive high", int'(irq), 1);

    phase = "R5";
    pulse(0, 0);
    rd(0, d);      chk("R5 masked not recorded", d, 0);
    chk("R5 pin inactive", int'(irq), 1);

    phase = "R4";
    wr(NG, 8'h00);
    rd(NG, d);     chk("R4 mask readback", d, 0);
    pulse(0, 0);
    chk("R8 pin low active", int'(irq), 0);
    rd(2*NG+1, d); chk("R7 summary group0", d, 1);
    phase = "R3";
    rd(0, d);      chk("R3 status read", d, 1);
    rd(0, d);      chk("R3 cleared after read", d, 0);
    chk("R8 pin back inactive", int'(irq), 1);

    phase = "R2";
    @(negedge clk); ev[0] = 1'b1;
    repeat (2) @(negedge clk);
    rd(0, d);      chk("R2 held input sets once", d, 1);
    rd(0, d);      chk("R2 no re-set while held", d, 0);
    @(negedge clk); ev[0] = 1'b0;

    phase = "R3";
    pulse(0, 1);
    @(negedge clk); rd_en = 1; addr = 0; ev[2] = 1'b1;
    @(negedge clk); rd_en = 0; ev[2] = 1'b0; d = int'(rdata);
    chk("R3 read returns old", d, 8'h02);
    rd(0, d);      chk("R3 event in read cycle kept", d, 8'h04);

    phase = "R6";
    wr(2*NG, 1);
    pulse(1, 5);
    chk("R6 masked visible pin inactive", int'(irq), 1);
    rd(2*NG+1, d); chk("R6 summary hides masked", d, 0);
    rd(1, d);      chk("R6 masked recorded", d, 8'h20);

    phase = "R9";
    pulse(2, 3);
    chk("R9 before unmask", int'(irq), 1);
    wr(NG+2, 8'hF7);
    chk("R9 pin active after unmask", int'(irq), 0);

    phase = "R8";
    wr(2*NG, 3);
    chk("R8 active-high pin", int'(irq), 1);
    phase = "R10";
    wr(2, 0);
    rd(2*NG+1, d); chk("R10 status write ignored", d, 8'h04);
    wr(2*NG+1, 0);
    rd(2*NG+1, d); chk("R10 summary write ignored", d, 8'h04);
    rd(15, d);     chk("R10 unmapped reads zero", d, 0);
    rd(2, d);      chk("R3 status2 read", d, 8'h08);
    chk("R8 active-high idle", int'(irq), 0);

    phase = "R7";
    repeat (600) begin
      @(negedge clk);
      ev    = $urandom;
      wr_en = ($urandom % 4) == 0;
      rd_en = ($urandom % 3) == 0;
      addr  = AW'($urandom % 16);
      wdata = 8'($urandom);
    end
    @(negedge clk); ev = '0; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule